// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block watches the exception sources of an in-order five-stage pipeline and decides, every cycle, whether control must pass to the exception handler. Synchronous faults can arise at fetch (instruction page fault), at decode (undefined instruction), at execute (arithmetic overflow) and at memory access (data page fault). An asynchronous request arrives on a separate interrupt line. When several faults are raised in the same cycle, the one belonging to the oldest instruction is chosen. An instruction further down the pipe is older, so memory access wins over execute, execute over decode and decode over fetch.

In the cycle a fault is selected, the block raises write strobes for its cause and exception-PC registers, flushes the faulting stage and every younger stage, and steers the fetch PC mux to a fixed handler address. Stages older than the fault are left alone so that they can retire. Flushing the faulting stage also suppresses its own register and memory writes. An interrupt is only taken in a cycle with no synchronous fault. It is treated as falling between instructions: only the fetch stage is squashed, the PC of the fetched instruction is saved as the resume point, and everything already past fetch completes.

Top module: `exc_ctl`

## Requirements
- R1: After reset, the cause register reads 0 and the exception-PC register reads 0.
- R2: Among simultaneous synchronous faults, the stage taken is the oldest, ranked memory access > execute > decode > fetch.
- R3: The recorded cause code depends on the taken source: 5 for a data page fault (memory stage), 12 for overflow (execute), 10 for an undefined instruction (decode), 4 for an instruction page fault (fetch) and 0 for an interrupt.
- R4: In a cycle where an exception is taken, `cause_we` and `epc_we` are both high in that same cycle. After the next rising clock edge, `cause_q` holds the code and `epc_q` holds the PC of the taken stage.
- R5: A synchronous fault taken at a stage raises the flush of that stage and of every younger stage, and leaves every older stage unflushed.
- R6: An interrupt is taken only when no synchronous fault is present. When taken, it flushes the fetch stage alone, records cause 0 and saves `if_pc`.
- R7: `pc_sel_handler` is high exactly in cycles where an exception or interrupt is taken, and `handler_pc` always equals the `HANDLER_PC` parameter.
- R8: In cycles where nothing is taken, the strobes are low, no flush is raised, and `cause_q` and `epc_q` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_pf | input | 1 | Instruction page fault from the fetch stage |
| id_undef | input | 1 | Undefined instruction from the decode stage |
| ex_ovf | input | 1 | Arithmetic overflow from the execute stage |
| mem_pf | input | 1 | Data page fault from the memory stage |
| irq | input | 1 | Asynchronous interrupt request |
| if_pc | input | XLEN | PC of the instruction in fetch |
| id_pc | input | XLEN | PC of the instruction in decode |
| ex_pc | input | XLEN | PC of the instruction in execute |
| mem_pc | input | XLEN | PC of the instruction in memory access |
| cause_we | output | 1 | Cause register write strobe |
| epc_we | output | 1 | Exception-PC register write strobe |
| cause_q | output | CW | Cause register value |
| epc_q | output | XLEN | Exception-PC register value |
| flush_if | output | 1 | Squash the fetch stage |
| flush_id | output | 1 | Squash the decode stage |
| flush_ex | output | 1 | Squash the execute stage |
| flush_mem | output | 1 | Squash the memory stage and block its writes |
| pc_sel_handler | output | 1 | Select the handler address at the PC mux |
| handler_pc | output | XLEN | Fixed handler address |

## Verification
A wrong ranking between stages shows up in the same cycle as the request. The flush pattern is then too long or too short, and the cause and PC loaded at the following edge come from the wrong stage. A corrupted cause or exception-PC register is visible one edge after the strobe. It stays visible until the next taken exception, so a stuck or unintended hold shows at the first compare after that edge. The bench drives every combination of the four fault lines and the interrupt, with distinct PCs, against a behavioural model compared every cycle.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;
    localparam int NSTG    = 4;
    localparam int STG_IF  = 0;
    localparam int STG_ID  = 1;
    localparam int STG_EX  = 2;
    localparam int STG_MEM = 3;
    localparam int CW      = 5;

    localparam logic [CW-1:0] CODE_INT   = 5'd0;
    localparam logic [CW-1:0] CODE_IPF   = 5'd4;
    localparam logic [CW-1:0] CODE_DPF   = 5'd5;
    localparam logic [CW-1:0] CODE_UNDEF = 5'd10;
    localparam logic [CW-1:0] CODE_OVF   = 5'd12;

    function automatic logic [CW-1:0] stage_code(input int stg);
        case (stg)
            STG_MEM: stage_code = CODE_DPF;
            STG_EX:  stage_code = CODE_OVF;
            STG_ID:  stage_code = CODE_UNDEF;
            default: stage_code = CODE_IPF;
        endcase
    endfunction
endpackage

// File: rtl/exc_prio.sv
module exc_prio #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // higher index = later stage = older instruction
    for (genvar i = 0; i < N; i++) begin : g_rank
        if (i == N-1) begin : g_top
            assign grant[i] = req[i];
        end else begin : g_low
            assign grant[i] = req[i] & ~(|req[N-1:i+1]);
        end
    end
    assign any = |req;

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R2
    oldest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req[N-1] |-> (grant == (N'(1) << (N-1))));
endmodule

// File: rtl/exc_flush.sv
module exc_flush #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] grant,
    output logic [N-1:0] flush
);
    // a stage is squashed when it or any older stage was granted
    for (genvar i = 0; i < N; i++) begin : g_mask
        assign flush[i] = |grant[N-1:i];
    end

    for (genvar i = 0; i < N-1; i++) begin : g_chk
        // R5
        younger_flushed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush[i+1] |-> flush[i]);
    end
endmodule

// File: rtl/exc_regs.sv
module exc_regs #(
    parameter int XLEN = 32,
    parameter int CW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [CW-1:0]   cause_in,
    input  logic [XLEN-1:0] pc_in,
    output logic [CW-1:0]   cause_q,
    output logic [XLEN-1:0] epc_q
);
    typedef struct packed {
        logic [CW-1:0]   cause;
        logic [XLEN-1:0] epc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.cause = cause_in;
            st_d.epc   = pc_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_q = st_q.cause;
    assign epc_q   = st_q.epc;

    // R4
    epc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (epc_q == $past(pc_in) && cause_q == $past(cause_in)));
    // R8
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(cause_q) && $stable(epc_q)));
endmodule

// File: rtl/exc_ctl.sv
module exc_ctl
    import exc_ctl_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter logic [31:0] HANDLER_PC = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            if_pf,
    input  logic            id_undef,
    input  logic            ex_ovf,
    input  logic            mem_pf,
    input  logic            irq,
    input  logic [XLEN-1:0] if_pc,
    input  logic [XLEN-1:0] id_pc,
    input  logic [XLEN-1:0] ex_pc,
    input  logic [XLEN-1:0] mem_pc,
    output logic            cause_we,
    output logic            epc_we,
    output logic [CW-1:0]   cause_q,
    output logic [XLEN-1:0] epc_q,
    output logic            flush_if,
    output logic            flush_id,
    output logic            flush_ex,
    output logic            flush_mem,
    output logic            pc_sel_handler,
    output logic [XLEN-1:0] handler_pc
);
    logic [NSTG-1:0] req, grant, fmask;
    logic            any_sync, int_take, taken;
    logic [XLEN-1:0] stg_pc [NSTG];
    logic [XLEN-1:0] sync_pc, sel_pc;
    logic [CW-1:0]   sync_code, sel_code;

    assign req[STG_IF]  = if_pf;
    assign req[STG_ID]  = id_undef;
    assign req[STG_EX]  = ex_ovf;
    assign req[STG_MEM] = mem_pf;

    assign stg_pc[STG_IF]  = if_pc;
    assign stg_pc[STG_ID]  = id_pc;
    assign stg_pc[STG_EX]  = ex_pc;
    assign stg_pc[STG_MEM] = mem_pc;

    exc_prio #(.N(NSTG)) u_prio (
        .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .any(any_sync)
    );

    exc_flush #(.N(NSTG)) u_flush (
        .clk(clk), .rst_n(rst_n), .grant(grant), .flush(fmask)
    );

    always_comb begin
        sync_pc   = '0;
        sync_code = '0;
        for (int i = 0; i < NSTG; i++) begin
            if (grant[i]) begin
                sync_pc   = sync_pc | stg_pc[i];
                sync_code = sync_code | stage_code(i);
            end
        end
    end

    assign int_take = irq & ~any_sync;
    assign taken    = any_sync | int_take;
    assign sel_pc   = any_sync ? sync_pc   : if_pc;
    assign sel_code = any_sync ? sync_code : CODE_INT;

    exc_regs #(.XLEN(XLEN), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(taken),
        .cause_in(sel_code), .pc_in(sel_pc),
        .cause_q(cause_q), .epc_q(epc_q)
    );

    assign cause_we       = taken;
    assign epc_we         = taken;
    assign flush_if       = fmask[STG_IF] | int_take;
    assign flush_id       = fmask[STG_ID];
    assign flush_ex       = fmask[STG_EX];
    assign flush_mem      = fmask[STG_MEM];
    assign pc_sel_handler = taken;
    assign handler_pc     = XLEN'(HANDLER_PC);

    // R6
    irq_only_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(if_pf || id_undef || ex_ovf || mem_pf)) |-> (flush_if && !flush_id));
    // R7
    redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel_handler |-> (flush_if && cause_we));
    // R8
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_sel_handler |-> !(flush_if || flush_id || flush_ex || flush_mem));
endmodule

// File: tb/tb_exc_ctl.sv
module tb_exc_ctl;
    localparam int XLEN = 32;
    localparam logic [31:0] HPC = 32'h0000_1000;

    logic clk = 0, rst_n = 0;
    logic if_pf = 0, id_undef = 0, ex_ovf = 0, mem_pf = 0, irq = 0;
    logic [XLEN-1:0] if_pc = 0, id_pc = 0, ex_pc = 0, mem_pc = 0;
    logic cause_we, epc_we, flush_if, flush_id, flush_ex, flush_mem, pc_sel_handler;
    logic [4:0] cause_q;
    logic [XLEN-1:0] epc_q, handler_pc;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [4:0]  m_cause = 0;
    logic [31:0] m_epc = 0;

    always #4 clk = ~clk;

    exc_ctl #(.XLEN(XLEN), .HANDLER_PC(HPC)) dut (
        .clk(clk), .rst_n(rst_n), .if_pf(if_pf), .id_undef(id_undef),
        .ex_ovf(ex_ovf), .mem_pf(mem_pf), .irq(irq), .if_pc(if_pc),
        .id_pc(id_pc), .ex_pc(ex_pc), .mem_pc(mem_pc), .cause_we(cause_we),
        .epc_we(epc_we), .cause_q(cause_q), .epc_q(epc_q), .flush_if(flush_if),
        .flush_id(flush_id), .flush_ex(flush_ex), .flush_mem(flush_mem),
        .pc_sel_handler(pc_sel_handler), .handler_pc(handler_pc)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // model: returns taken level (0 none,1 irq,2 IF,3 ID,4 EX,5 MEM)
    task automatic step(input logic [4:0] f, input string tag);
        int lvl;
        logic [4:0] ec;
        logic [31:0] ep;
        {irq, mem_pf, ex_ovf, id_undef, if_pf} = f;
        if_pc  = 32'h100 + 32'($urandom_range(0, 255)) * 4;
        id_pc  = 32'h2000 + 32'($urandom_range(0, 255)) * 4;
        ex_pc  = 32'h3000 + 32'($urandom_range(0, 255)) * 4;
        mem_pc = 32'h4000 + 32'($urandom_range(0, 255)) * 4;
        #1;
        if (mem_pf)        begin lvl = 5; ec = 5;  ep = mem_pc; end
        else if (ex_ovf)   begin lvl = 4; ec = 12; ep = ex_pc;  end
        else if (id_undef) begin lvl = 3; ec = 10; ep = id_pc;  end
        else if (if_pf)    begin lvl = 2; ec = 4;  ep = if_pc;  end
        else if (irq)      begin lvl = 1; ec = 0;  ep = if_pc;  end
        else               begin lvl = 0; ec = 0;  ep = 0;      end
        chk({"R4 cause_we ", tag}, 32'(cause_we), 32'(lvl != 0));
        chk({"R4 epc_we ", tag}, 32'(epc_we), 32'(lvl != 0));
        chk({"R7 pc_sel_handler ", tag}, 32'(pc_sel_handler), 32'(lvl != 0));
        chk({"R7 handler_pc ", tag}, handler_pc, HPC);
        chk({"R5 R6 flush_if ", tag}, 32'(flush_if), 32'(lvl >= 1));
        chk({"R5 flush_id ", tag}, 32'(flush_id), 32'(lvl >= 3));
        chk({"R5 flush_ex ", tag}, 32'(flush_ex), 32'(lvl >= 4));
        chk({"R5 flush_mem ", tag}, 32'(flush_mem), 32'(lvl >= 5));
        chk({"R8 cause_q ", tag}, 32'(cause_q), 32'(m_cause));
        chk({"R8 epc_q ", tag}, epc_q, m_epc);
        @(posedge clk);
        if (lvl != 0) begin m_cause = ec; m_epc = ep; end
        @(negedge clk);
        #1;
        chk({"R2 R3 cause_q after edge ", tag}, 32'(cause_q), 32'(m_cause));
        chk({"R2 R4 epc_q after edge ", tag}, epc_q, m_epc);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset cause_q", 32'(cause_q), 0);
        chk("R1 reset epc_q", epc_q, 0);
        rst_n = 1;
        @(negedge clk);
        // R1 values persist with no request
        step(5'b00000, "idle");
        // R3 single sources
        step(5'b01000, "R3 data page fault");
        step(5'b00100, "R3 overflow");
        step(5'b00010, "R3 undefined");
        step(5'b00001, "R3 fetch page fault");
        step(5'b10000, "R6 interrupt alone");
        step(5'b00000, "R8 hold");
        // R2 mixed priority
        step(5'b01111, "R2 all sync");
        step(5'b00111, "R2 ex over id/if");
        step(5'b00011, "R2 id over if");
        step(5'b11000, "R6 irq with mem");
        step(5'b10001, "R6 irq with if");
        // exhaustive sweep
        for (int v = 0; v < 32; v++) step(5'(v), "sweep");
        for (int n = 0; n < 300; n++) step(5'($urandom_range(0, 31)), "random");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule